// File: doc/BRIEF.md
# Pipeline memory-miss stall controller

This block is the hazard and trap controller for a five-stage in-order pipeline whose stages are fetch, decode, execute, memory and writeback. It looks at the events the memory system raises in the current cycle and decides, in that same cycle, which stage registers hold their contents, which take a no-op bubble, which are flushed, and whether the fetch PC is redirected.

The three kinds of memory event are handled in three different ways. A fetch miss holds only the fetch PC and feeds bubbles into decode. A data miss freezes the pipe from fetch to the memory stage and feeds bubbles into writeback. A page fault does not stall at all: it traps. The trap flushes the faulting instruction and everything younger, sends fetch to a fixed handler address, and records the faulting PC, the faulting address and a cause code. An asynchronous interrupt is taken between instructions, at the execute-stage boundary. A return-from-exception input sends fetch back to the saved PC and ends the trap.

All the control outputs are combinational from the inputs and the current state. The exception registers and the trap-pending flag change on the next rising clock edge.

Top module: `pipe_miss_ctl`

## Requirements
- R1: With only a fetch miss raised, stage_hold_o is 5'b00001 and bubble_o is 5'b00010, with no flush and no redirect. Bit positions are 0 for fetch, 1 for decode, 2 for execute, 3 for memory and 4 for writeback, in every stage vector.
- R2: A data miss with no memory-stage fault gives stage_hold_o = 5'b01111 and bubble_o = 5'b10000. It gives no flush and no redirect, and it holds back any fetch fault, interrupt or return raised in the same cycle.
- R3: A memory-stage page fault gives flush_o = 5'b01111, leaves writeback alone, asserts redirect_o with redirect_pc_o equal to HANDLER_PC, and holds nothing.
- R4: After a memory-stage page fault, the next rising edge loads epc_o with pc_mem_i, badva_o with data_va_i, and cause_o with 2 for a load or 3 for a store (dfault_store_i high).
- R5: A fetch page fault that wins arbitration flushes fetch only (5'b00001) and redirects to HANDLER_PC. On the next edge epc_o and badva_o both hold pc_if_i and cause_o holds 1.
- R6: An interrupt that wins arbitration flushes fetch, decode and execute (5'b00111) and redirects to HANDLER_PC. On the next edge epc_o holds pc_ex_i and cause_o holds 0, and badva_o is not changed.
- R7: While trap_pending_o is high, irq_i has no effect on any output or on the exception registers.
- R8: A return that wins arbitration redirects to the current epc_o and flushes fetch and decode (5'b00011). trap_pending_o is low after the next edge.
- R9: While rst_n is low at a rising edge, epc_o, badva_o, cause_o and trap_pending_o become zero.
- R10: When several events arrive in one cycle, the winner follows this order, from highest to lowest: memory fault, data miss, return, interrupt (if not masked), fetch fault, fetch miss. Only the winner acts.
- R11: Every taken trap asserts epc_we_o and cause_we_o in that cycle, and sets trap_pending_o on the next edge. badva_we_o is asserted only for the two page-fault kinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| imiss_i | input | 1 | Instruction fetch missed this cycle |
| dmiss_i | input | 1 | Memory-stage data access missed this cycle |
| ifault_i | input | 1 | Page fault on the fetch translation |
| dfault_i | input | 1 | Page fault on the memory-stage translation |
| dfault_store_i | input | 1 | Memory-stage access is a store (cause 3) rather than a load (cause 2) |
| irq_i | input | 1 | Asynchronous interrupt request |
| eret_i | input | 1 | Return-from-exception seen in execute |
| pc_if_i | input | AW | PC in fetch |
| pc_ex_i | input | AW | PC in execute |
| pc_mem_i | input | AW | PC in the memory stage |
| data_va_i | input | AW | Virtual data address in the memory stage |
| stage_hold_o | output | 5 | Per-stage hold enables |
| bubble_o | output | 5 | Per-stage no-op inject |
| flush_o | output | 5 | Per-stage flush to no-op |
| redirect_o | output | 1 | Load fetch PC with redirect_pc_o |
| redirect_pc_o | output | AW | Handler address or saved PC |
| epc_we_o | output | 1 | Saved-PC register write this cycle |
| badva_we_o | output | 1 | Faulting-address register write this cycle |
| cause_we_o | output | 1 | Cause register write this cycle |
| epc_o | output | AW | Saved PC of the trapped instruction |
| badva_o | output | AW | Faulting virtual address |
| cause_o | output | CAUSE_W | Trap cause code |
| trap_pending_o | output | 1 | Trap taken and not yet returned |

## Verification
The hold, bubble, flush, redirect and write-enable outputs answer in the same cycle as the event flags. The bench therefore drives a new set of flags just after a falling edge and compares these outputs 1 ns later, well before the next rising edge. The exception registers and the trap-pending flag only change on the rising edge after a trap or return. The bench updates its own register model at that edge and compares the registers in the following cycle, where they cannot depend on that cycle's inputs. The tag printed for each comparison is picked from the event the model expects, and cycles with more than one event raised are tagged with the priority requirement.

// File: rtl/pipe_miss_ctl_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the pipeline memory-miss stall controller.
// Assumes a five-stage in-order pipe. Stage bit positions in every
// per-stage vector: 0 fetch, 1 decode, 2 execute, 3 memory, 4 writeback.
package pipe_miss_ctl_pkg;

    localparam int NSTAGE = 5;
    localparam int ST_IF  = 0;
    localparam int ST_ID  = 1;
    localparam int ST_EX  = 2;
    localparam int ST_MEM = 3;
    localparam int ST_WB  = 4;

    // Cause codes written into the cause register
    localparam int CODE_IRQ    = 0;
    localparam int CODE_IFETCH = 1;
    localparam int CODE_LOAD   = 2;
    localparam int CODE_STORE  = 3;

    // Winning event of one cycle; the arbiter picks exactly one
    typedef enum logic [2:0] {
        EV_NONE   = 3'd0,
        EV_IMISS  = 3'd1,
        EV_IFAULT = 3'd2,
        EV_IRQ    = 3'd3,
        EV_ERET   = 3'd4,
        EV_DMISS  = 3'd5,
        EV_DFAULT = 3'd6
    } pm_event_e;

    // True for events that enter the trap handler
    function automatic logic takes_trap(pm_event_e ev);
        return (ev == EV_DFAULT) || (ev == EV_IFAULT) || (ev == EV_IRQ);
    endfunction

    // True for events that record a faulting address
    function automatic logic records_badva(pm_event_e ev);
        return (ev == EV_DFAULT) || (ev == EV_IFAULT);
    endfunction

    // Number of stages, counted from fetch, cleared by an event
    function automatic int flush_depth(pm_event_e ev);
        case (ev)
            EV_DFAULT: return ST_MEM + 1;
            EV_IRQ:    return ST_EX + 1;
            EV_ERET:   return ST_ID + 1;
            EV_IFAULT: return ST_IF + 1;
            default:   return 0;
        endcase
    endfunction

    // Number of stages, counted from fetch, held by an event
    function automatic int hold_depth(pm_event_e ev);
        case (ev)
            EV_DMISS: return ST_MEM + 1;
            EV_IMISS: return ST_IF + 1;
            default:  return 0;
        endcase
    endfunction

    // Stage that receives a bubble for an event, -1 for none
    function automatic int bubble_stage(pm_event_e ev);
        case (ev)
            EV_DMISS: return ST_WB;
            EV_IMISS: return ST_ID;
            default:  return -1;
        endcase
    endfunction

endpackage

// File: rtl/pipe_miss_event_arb.sv
`timescale 1ns/1ps
// Event arbiter: reduces the raw event flags of one cycle to a single
// winning event. Order, highest first: memory fault, data miss, return,
// interrupt (unless a trap is pending), fetch fault, fetch miss.
// Assumes all flags are synchronous to clk. Purely combinational.
module pipe_miss_event_arb
    import pipe_miss_ctl_pkg::*;
(
    input  logic      imiss_i,
    input  logic      dmiss_i,
    input  logic      ifault_i,
    input  logic      dfault_i,
    input  logic      irq_i,
    input  logic      eret_i,
    input  logic      trap_pending_i,
    output pm_event_e event_o
);

    logic irq_open;

    // Interrupts are masked until the current trap has returned
    always_comb irq_open = irq_i && !trap_pending_i;

    // Fixed-priority pick of the winning event
    always_comb begin
        if (dfault_i)
            event_o = EV_DFAULT;
        else if (dmiss_i)
            event_o = EV_DMISS;
        else if (eret_i)
            event_o = EV_ERET;
        else if (irq_open)
            event_o = EV_IRQ;
        else if (ifault_i)
            event_o = EV_IFAULT;
        else if (imiss_i)
            event_o = EV_IMISS;
        else
            event_o = EV_NONE;
    end

endmodule

// File: rtl/pipe_miss_stage_ctl.sv
`timescale 1ns/1ps
// Stage control: turns the winning event into per-stage hold, bubble
// and flush enables. One generate slice per stage. Holds and flushes
// cover a run of stages from fetch up to a depth chosen by the event.
// Assumes exactly one event per cycle (from the arbiter).
module pipe_miss_stage_ctl
    import pipe_miss_ctl_pkg::*;
#(
    parameter int NST = NSTAGE
) (
    input  pm_event_e      event_i,
    output logic [NST-1:0] hold_o,
    output logic [NST-1:0] bubble_o,
    output logic [NST-1:0] flush_o
);

    int n_hold;
    int n_flush;
    int b_stage;

    // Decode the event into run lengths and the bubble target
    always_comb begin
        n_hold  = hold_depth(event_i);
        n_flush = flush_depth(event_i);
        b_stage = bubble_stage(event_i);
    end

    for (genvar s = 0; s < NST; s++) begin : g_stage
        // Per-stage enables from the decoded run lengths
        always_comb begin
            hold_o[s]   = (s < n_hold);
            flush_o[s]  = (s < n_flush);
            bubble_o[s] = (s == b_stage);
        end
    end

endmodule

// File: rtl/pipe_miss_exc_regs.sv
`timescale 1ns/1ps
// Exception state: saved PC, faulting address, cause code and the
// trap-pending flag, plus the fetch redirect. On a trap the state is
// written at the next rising edge; on a return the pending flag clears.
// Assumes synchronous active-low reset and one event per cycle.
module pipe_miss_exc_regs
    import pipe_miss_ctl_pkg::*;
#(
    parameter int             AW         = 32,
    parameter int             CAUSE_W    = 4,
    parameter logic [AW-1:0]  HANDLER_PC = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  pm_event_e          event_i,
    input  logic               store_i,
    input  logic [AW-1:0]      pc_if_i,
    input  logic [AW-1:0]      pc_ex_i,
    input  logic [AW-1:0]      pc_mem_i,
    input  logic [AW-1:0]      data_va_i,
    output logic               redirect_o,
    output logic [AW-1:0]      redirect_pc_o,
    output logic               epc_we_o,
    output logic               badva_we_o,
    output logic               cause_we_o,
    output logic [AW-1:0]      epc_o,
    output logic [AW-1:0]      badva_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               pending_o
);

    logic               trap;
    logic [AW-1:0]      epc_nxt;
    logic [AW-1:0]      badva_nxt;
    logic [CAUSE_W-1:0] cause_nxt;

    // Write strobes for the three exception registers
    always_comb begin
        trap       = takes_trap(event_i);
        epc_we_o   = trap;
        cause_we_o = trap;
        badva_we_o = records_badva(event_i);
    end

    // Select the values captured for each kind of trap
    always_comb begin
        epc_nxt   = epc_o;
        badva_nxt = badva_o;
        cause_nxt = cause_o;
        case (event_i)
            EV_DFAULT: begin
                epc_nxt   = pc_mem_i;
                badva_nxt = data_va_i;
                cause_nxt = store_i ? CAUSE_W'(CODE_STORE) : CAUSE_W'(CODE_LOAD);
            end
            EV_IFAULT: begin
                epc_nxt   = pc_if_i;
                badva_nxt = pc_if_i;
                cause_nxt = CAUSE_W'(CODE_IFETCH);
            end
            EV_IRQ: begin
                epc_nxt   = pc_ex_i;
                cause_nxt = CAUSE_W'(CODE_IRQ);
            end
            default: ;
        endcase
    end

    // Fetch redirect: handler on a trap, saved PC on a return
    always_comb begin
        redirect_o    = trap || (event_i == EV_ERET);
        redirect_pc_o = (event_i == EV_ERET) ? epc_o : HANDLER_PC;
    end

    // Exception register update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_o   <= '0;
            badva_o <= '0;
            cause_o <= '0;
        end else begin
            if (epc_we_o)   epc_o   <= epc_nxt;
            if (badva_we_o) badva_o <= badva_nxt;
            if (cause_we_o) cause_o <= cause_nxt;
        end
    end

    // Trap-pending flag: set by a trap, cleared by a return
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_o <= 1'b0;
        else if (trap)
            pending_o <= 1'b1;
        else if (event_i == EV_ERET)
            pending_o <= 1'b0;
    end

endmodule

// File: rtl/pipe_miss_ctl.sv
`timescale 1ns/1ps
// Pipeline memory-miss stall controller, top level. Arbitrates the
// memory-system events of each cycle and drives stage holds, bubbles,
// flushes, the fetch redirect and the exception registers.
// Assumes a five-stage in-order pipe; control outputs are combinational.
module pipe_miss_ctl
    import pipe_miss_ctl_pkg::*;
#(
    parameter int            AW         = 32,
    parameter int            CAUSE_W    = 4,
    parameter logic [AW-1:0] HANDLER_PC = 32'h0000_1F00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               imiss_i,
    input  logic               dmiss_i,
    input  logic               ifault_i,
    input  logic               dfault_i,
    input  logic               dfault_store_i,
    input  logic               irq_i,
    input  logic               eret_i,
    input  logic [AW-1:0]      pc_if_i,
    input  logic [AW-1:0]      pc_ex_i,
    input  logic [AW-1:0]      pc_mem_i,
    input  logic [AW-1:0]      data_va_i,
    output logic [4:0]         stage_hold_o,
    output logic [4:0]         bubble_o,
    output logic [4:0]         flush_o,
    output logic               redirect_o,
    output logic [AW-1:0]      redirect_pc_o,
    output logic               epc_we_o,
    output logic               badva_we_o,
    output logic               cause_we_o,
    output logic [AW-1:0]      epc_o,
    output logic [AW-1:0]      badva_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               trap_pending_o
);

    pm_event_e win_ev;

    pipe_miss_event_arb u_arb (
        .imiss_i        (imiss_i),
        .dmiss_i        (dmiss_i),
        .ifault_i       (ifault_i),
        .dfault_i       (dfault_i),
        .irq_i          (irq_i),
        .eret_i         (eret_i),
        .trap_pending_i (trap_pending_o),
        .event_o        (win_ev)
    );

    pipe_miss_stage_ctl #(
        .NST (NSTAGE)
    ) u_stage (
        .event_i  (win_ev),
        .hold_o   (stage_hold_o),
        .bubble_o (bubble_o),
        .flush_o  (flush_o)
    );

    pipe_miss_exc_regs #(
        .AW         (AW),
        .CAUSE_W    (CAUSE_W),
        .HANDLER_PC (HANDLER_PC)
    ) u_exc (
        .clk           (clk),
        .rst_n         (rst_n),
        .event_i       (win_ev),
        .store_i       (dfault_store_i),
        .pc_if_i       (pc_if_i),
        .pc_ex_i       (pc_ex_i),
        .pc_mem_i      (pc_mem_i),
        .data_va_i     (data_va_i),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o),
        .epc_we_o      (epc_we_o),
        .badva_we_o    (badva_we_o),
        .cause_we_o    (cause_we_o),
        .epc_o         (epc_o),
        .badva_o       (badva_o),
        .cause_o       (cause_o),
        .pending_o     (trap_pending_o)
    );

endmodule

// File: rtl/pipe_miss_ctl_chk.sv
`timescale 1ns/1ps
// Property checker for pipe_miss_ctl, attached by bind. Watches the
// top-level ports only; relates event flags to the control outputs
// and to the exception registers one cycle later.
module pipe_miss_ctl_chk #(
    parameter int            AW         = 32,
    parameter int            CAUSE_W    = 4,
    parameter logic [AW-1:0] HANDLER_PC = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               imiss_i,
    input logic               dmiss_i,
    input logic               ifault_i,
    input logic               dfault_i,
    input logic               dfault_store_i,
    input logic               irq_i,
    input logic               eret_i,
    input logic [AW-1:0]      pc_mem_i,
    input logic [AW-1:0]      data_va_i,
    input logic [4:0]         stage_hold_o,
    input logic [4:0]         bubble_o,
    input logic [4:0]         flush_o,
    input logic               redirect_o,
    input logic [AW-1:0]      redirect_pc_o,
    input logic [AW-1:0]      epc_o,
    input logic [AW-1:0]      badva_o,
    input logic [CAUSE_W-1:0] cause_o,
    input logic               trap_pending_o
);

    logic only_imiss;
    always_comb only_imiss = imiss_i && !dmiss_i && !ifault_i && !dfault_i
                             && !eret_i && !(irq_i && !trap_pending_o);

    // R1
    imiss_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        only_imiss |-> (stage_hold_o == 5'b00001) && (bubble_o == 5'b00010) && !redirect_o);

    // R2
    dmiss_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmiss_i && !dfault_i) |-> (stage_hold_o == 5'b01111) && (bubble_o == 5'b10000)
                                   && (flush_o == 5'b00000) && !redirect_o);

    // R3
    dfault_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dfault_i |-> (flush_o == 5'b01111) && redirect_o && (redirect_pc_o == HANDLER_PC)
                     && (stage_hold_o == 5'b00000));

    // R4
    dfault_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dfault_i |=> (epc_o == $past(pc_mem_i)) && (badva_o == $past(data_va_i))
                     && (cause_o == ($past(dfault_store_i) ? CAUSE_W'(3) : CAUSE_W'(2))));

    // R7
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_pending_o && !dfault_i && !ifault_i && !eret_i) |-> !redirect_o);

    // R8
    eret_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_i && !dfault_i && !dmiss_i) |=> !trap_pending_o);

    // R8
    eret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_i && !dfault_i && !dmiss_i) |-> redirect_o && (redirect_pc_o == epc_o)
                                             && (flush_o == 5'b00011));

    // R10
    hold_flush_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_hold_o & flush_o) == 5'b00000);

    // R11
    trap_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && (redirect_pc_o == HANDLER_PC) && !(eret_i && !dfault_i && !dmiss_i))
        |=> trap_pending_o);

endmodule

bind pipe_miss_ctl pipe_miss_ctl_chk #(
    .AW         (AW),
    .CAUSE_W    (CAUSE_W),
    .HANDLER_PC (HANDLER_PC)
) u_pipe_miss_ctl_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .imiss_i        (imiss_i),
    .dmiss_i        (dmiss_i),
    .ifault_i       (ifault_i),
    .dfault_i       (dfault_i),
    .dfault_store_i (dfault_store_i),
    .irq_i          (irq_i),
    .eret_i         (eret_i),
    .pc_mem_i       (pc_mem_i),
    .data_va_i      (data_va_i),
    .stage_hold_o   (stage_hold_o),
    .bubble_o       (bubble_o),
    .flush_o        (flush_o),
    .redirect_o     (redirect_o),
    .redirect_pc_o  (redirect_pc_o),
    .epc_o          (epc_o),
    .badva_o        (badva_o),
    .cause_o        (cause_o),
    .trap_pending_o (trap_pending_o)
);

// File: tb/test_pipe_miss_ctl.sv
`timescale 1ns/1ps
module test_pipe_miss_ctl;

    localparam int          AW      = 32;
    localparam int          CAUSE_W = 4;
    localparam logic [31:0] HPC     = 32'h0000_1F00;

    localparam int E_NONE = 0, E_IMISS = 1, E_IFAULT = 2, E_IRQ = 3,
                   E_ERET = 4, E_DMISS = 5, E_DFAULT = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic imiss, dmiss, ifault, dfault, dstore, irq, eret;
    logic [AW-1:0] pc_if, pc_ex, pc_mem, dva;
    logic [4:0] hold, bubble, flush;
    logic redirect, epc_we, badva_we, cause_we, pending;
    logic [AW-1:0] redirect_pc, epc, badva;
    logic [CAUSE_W-1:0] cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference state
    logic [31:0] m_epc, m_badva;
    logic [3:0]  m_cause;
    bit          m_pend;
    int          m_last;

    always #4 clk = ~clk;

    pipe_miss_ctl #(.AW(AW), .CAUSE_W(CAUSE_W), .HANDLER_PC(HPC)) i_pipe_miss_ctl (
        .clk(clk), .rst_n(rst_n), .imiss_i(imiss), .dmiss_i(dmiss), .ifault_i(ifault),
        .dfault_i(dfault), .dfault_store_i(dstore), .irq_i(irq), .eret_i(eret),
        .pc_if_i(pc_if), .pc_ex_i(pc_ex), .pc_mem_i(pc_mem), .data_va_i(dva),
        .stage_hold_o(hold), .bubble_o(bubble), .flush_o(flush), .redirect_o(redirect),
        .redirect_pc_o(redirect_pc), .epc_we_o(epc_we), .badva_we_o(badva_we),
        .cause_we_o(cause_we), .epc_o(epc), .badva_o(badva), .cause_o(cause),
        .trap_pending_o(pending)
    );

    function automatic int f_event(bit im, bit dm, bit ifl, bit dfl, bit iq, bit er, bit pend);
        if (dfl) return E_DFAULT;
        if (dm) return E_DMISS;
        if (er) return E_ERET;
        if (iq && !pend) return E_IRQ;
        if (ifl) return E_IFAULT;
        if (im) return E_IMISS;
        return E_NONE;
    endfunction

    function automatic string f_tag(int ev, int nraised, bit masked_irq);
        if (nraised > 1) return "R10";
        case (ev)
            E_IMISS:  return "R1";
            E_DMISS:  return "R2";
            E_DFAULT: return "R3";
            E_IFAULT: return "R5";
            E_IRQ:    return "R6";
            E_ERET:   return "R8";
            default:  return masked_irq ? "R7" : "R11";
        endcase
    endfunction

    function automatic string f_regtag(int ev);
        case (ev)
            E_DFAULT: return "R4";
            E_IFAULT: return "R5";
            E_IRQ:    return "R6";
            E_ERET:   return "R8";
            default:  return "R11";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one cycle of events, check outputs, advance the model
    task automatic step(bit im, bit dm, bit ifl, bit dfl, bit st, bit iq, bit er,
                        logic [31:0] pif, logic [31:0] pex, logic [31:0] pmem, logic [31:0] va);
        int ev;
        int nr;
        string t;
        string rt;
        bit trap;
        imiss = im; dmiss = dm; ifault = ifl; dfault = dfl; dstore = st;
        irq = iq; eret = er; pc_if = pif; pc_ex = pex; pc_mem = pmem; dva = va;
        #1;
        ev = f_event(im, dm, ifl, dfl, iq, er, m_pend);
        nr = int'(im) + int'(dm) + int'(ifl) + int'(dfl) + int'(er) + int'(iq && !m_pend);
        t  = f_tag(ev, nr, iq && m_pend);
        rt = f_regtag(m_last);
        // registers reflect the previous cycle's event
        chk(rt, "epc", epc, m_epc);
        chk(rt, "badva", badva, m_badva);
        chk(rt, "cause", 32'(cause), 32'(m_cause));
        chk((m_last == E_ERET) ? "R8" : "R11", "pending", 32'(pending), 32'(m_pend));
        // combinational controls
        chk(t, "hold", 32'(hold), (ev == E_DMISS) ? 32'h0F : (ev == E_IMISS) ? 32'h01 : 32'h0);
        chk(t, "bubble", 32'(bubble), (ev == E_DMISS) ? 32'h10 : (ev == E_IMISS) ? 32'h02 : 32'h0);
        chk(t, "flush", 32'(flush), (ev == E_DFAULT) ? 32'h0F : (ev == E_IRQ) ? 32'h07 :
                                     (ev == E_ERET) ? 32'h03 : (ev == E_IFAULT) ? 32'h01 : 32'h0);
        trap = (ev == E_DFAULT) || (ev == E_IFAULT) || (ev == E_IRQ);
        chk(t, "redirect", 32'(redirect), 32'(trap || ev == E_ERET));
        if (trap || ev == E_ERET)
            chk(t, "redirect_pc", redirect_pc, (ev == E_ERET) ? m_epc : HPC);
        chk(t, "epc_we", 32'(epc_we), 32'(trap));
        chk(t, "cause_we", 32'(cause_we), 32'(trap));
        chk(t, "badva_we", 32'(badva_we), 32'(ev == E_DFAULT || ev == E_IFAULT));
        // model update at the coming edge
        case (ev)
            E_DFAULT: begin m_epc = pmem; m_badva = va; m_cause = st ? 4'd3 : 4'd2; end
            E_IFAULT: begin m_epc = pif;  m_badva = pif; m_cause = 4'd1; end
            E_IRQ:    begin m_epc = pex;  m_cause = 4'd0; end
            default: ;
        endcase
        if (trap) m_pend = 1'b1;
        else if (ev == E_ERET) m_pend = 1'b0;
        m_last = ev;
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd7341);
        {imiss, dmiss, ifault, dfault, dstore, irq, eret} = '0;
        pc_if = '0; pc_ex = '0; pc_mem = '0; dva = '0;
        m_epc = '0; m_badva = '0; m_cause = '0; m_pend = 0; m_last = E_NONE;
        // R9: reset clears exception state (seed it first with a trap)
        rst_n = 1'b1;
        @(negedge clk);
        dfault = 1'b1; pc_mem = 32'hDEAD_0000; dva = 32'hBEEF_0000;
        @(negedge clk);
        dfault = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9", "epc", epc, 32'h0);
        chk("R9", "badva", badva, 32'h0);
        chk("R9", "cause", 32'(cause), 32'h0);
        chk("R9", "pending", 32'(pending), 32'h0);
        rst_n = 1'b1;
        // directed corner cases
        step(0,0,0,0,0,0,0, 32'h100, 32'h0F8, 32'h0F4, 32'h0);
        step(1,0,0,0,0,0,0, 32'h104, 32'h0FC, 32'h0F8, 32'h0);        // R1
        step(1,1,0,0,0,0,0, 32'h104, 32'h0FC, 32'h0F8, 32'h5000);     // R10 dmiss over imiss
        step(0,1,0,0,0,0,0, 32'h104, 32'h0FC, 32'h0F8, 32'h5000);     // R2
        step(1,1,1,1,0,1,1, 32'h400010, 32'h530FF8, 32'h530FFC, 32'h531020); // R10 dfault wins
        step(0,0,0,0,0,1,0, 32'h1F00, 32'h0, 32'h0, 32'h0);           // R7 masked
        step(0,0,0,0,0,0,1, 32'h1F04, 32'h1F00, 32'h0, 32'h0);        // R8
        step(0,0,0,1,1,0,0, 32'h200, 32'h1F8, 32'h1FC, 32'h7770);     // R3 R4 store
        step(0,1,0,0,0,0,1, 32'h1F00, 32'h0, 32'h0, 32'h0);           // R2 eret held off
        step(0,0,0,0,0,0,1, 32'h1F04, 32'h1F00, 32'h0, 32'h0);        // R8
        step(0,0,1,0,0,1,0, 32'h3000, 32'h2FF8, 32'h2FF4, 32'h0);     // R10 irq over ifault
        step(0,0,0,0,0,0,1, 32'h1F04, 32'h1F00, 32'h0, 32'h0);        // R8
        step(1,0,1,0,0,0,0, 32'h8000, 32'h7FF8, 32'h7FF4, 32'h0);     // R5 R10
        step(0,0,0,0,0,0,0, 32'h1F00, 32'h0, 32'h0, 32'h0);           // R11 pending held
        step(0,0,0,0,0,0,1, 32'h1F04, 32'h1F00, 32'h0, 32'h0);
        // constrained random
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0,5) == 0, $urandom_range(0,7) == 0,
                 $urandom_range(0,11) == 0, $urandom_range(0,13) == 0,
                 $urandom_range(0,1) == 1, $urandom_range(0,9) == 0,
                 $urandom_range(0,9) == 0,
                 $urandom, $urandom, $urandom, $urandom);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule